// File: doc/BRIEF.md
# Clock-Enable Divider with Low-Power Modes

This block produces the system clock-enable pulse for a single-clock design. The fast clock `clk` is the high-frequency source; a slow 32 kHz timebase and an optional alternate oscillator arrive as synchronous single-cycle tick inputs. Logic downstream advances only on cycles where `sys_ce` is high. The configuration is written in a single operation. It holds a two-bit divide code, a low-power enable, a switchback enable and an alternate-source select.

With low power off, the divide code picks a ratio of 1, 2, 4 or 8 source ticks per enable. Low power with code 0 divides by 256. Low power with code 1 runs the enable straight from the 32 kHz ticks. When switchback is armed, an interrupt request or a serial-port activity pulse clears the low-power enable in hardware. The divider then returns to the normal ratio given by the code. Every ratio or mode change waits for the current divider period to complete, so no enable period is ever cut short.

Top module: `clkpm_ctrl`

## Requirements
- R1: Reset clears the stored configuration (code 0, low power off, switchback off, fast clock selected), holds `sys_ce`, `lp_active`, `lf_active` and `swb_taken` low, and leaves the divider in ratio 1. `sys_ce` is first high after the first rising edge following reset release.
- R2: With low power off, code d (0,1,2,3) gives one `sys_ce` cycle every 2^d source ticks, so ratios 1, 2, 4 and 8.
- R3: Low power on with code 0 gives one `sys_ce` cycle every 256 source ticks. While this mode is active, `lp_active` is 1 and `lf_active` is 0.
- R4: Low power on with code 1 makes `sys_ce` high on the cycle after each `lf_tick` pulse. While this mode is active, `lp_active` and `lf_active` are both 1.
- R5: A write that requests low power with code 2 or 3 stores the code but leaves `cfg_pm` at 0.
- R6: When switchback and low power are both set and `irq_evt` or `ser_evt` pulses with no write in the same cycle, `cfg_pm` is 0 and `swb_taken` is 1 on the following cycle.
- R7: An event pulse has no effect on `cfg_pm` or `swb_taken` while switchback is off.
- R8: A write in the same cycle as a qualifying event takes priority, so the written low-power value is stored and `swb_taken` stays 0.
- R9: A new ratio or mode takes effect only at the divider's terminal count. The enable period in progress completes at the old ratio, and `lp_active` and `lf_active` change only at that point.
- R10: With `cfg_alt` set, the normal and divide-by-256 modes count `alt_tick` pulses instead of `clk` cycles. This starts with the first cycle after the write, and no enable occurs on a cycle that follows one without an `alt_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock, sole clock of the block |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_div | input | 2 | Divide code to write |
| wr_pm | input | 1 | Low-power enable to write |
| wr_swb | input | 1 | Switchback enable to write |
| wr_alt | input | 1 | Alternate-source select to write |
| irq_evt | input | 1 | Interrupt request pulse |
| ser_evt | input | 1 | Serial-port activity pulse |
| lf_tick | input | 1 | One-cycle pulse per 32 kHz period |
| alt_tick | input | 1 | One-cycle pulse per alternate-oscillator period |
| sys_ce | output | 1 | System clock-enable pulse |
| cfg_div | output | 2 | Stored divide code |
| cfg_pm | output | 1 | Stored low-power enable |
| cfg_swb | output | 1 | Stored switchback enable |
| cfg_alt | output | 1 | Stored alternate-source select |
| lp_active | output | 1 | A low-power mode is in effect |
| lf_active | output | 1 | The 32 kHz mode is in effect |
| swb_taken | output | 1 | Pulse one cycle after a switchback |

## Verification
A wrong divider count or a wrong active mode appears on `sys_ce` as a misplaced pulse. This shows within one enable period, which is at most 256 source ticks or one `lf_tick` interval. A wrong configuration bit appears on the cycle after the write or event that set it, because the stored fields are visible directly as ports. The bench runs a behavioural model alongside the design and compares every output on every cycle. Mode changes that land early or late are therefore caught at the first pulse that differs.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_PM256 = 2'd1,
    MODE_LF    = 2'd2
  } mode_e;

  typedef struct packed {
    logic [1:0] div;
    logic       pm;
    logic       swb;
    logic       alt;
  } cfg_t;

  // Mode the stored configuration asks for.
  function automatic mode_e want_mode(cfg_t c);
    if (c.pm && c.div == 2'd0) return MODE_PM256;
    if (c.pm && c.div == 2'd1) return MODE_LF;
    return MODE_NORM;
  endfunction

  // Highest count value of one enable period for a divider mode.
  function automatic int unsigned last_count(mode_e m, logic [1:0] d,
                                             int unsigned pm_log2);
    case (m)
      MODE_NORM:  return (32'd1 << d) - 32'd1;
      MODE_PM256: return (32'd1 << pm_log2) - 32'd1;
      default:    return 32'd0;
    endcase
  endfunction

  // Low power may only be held with a code that selects a low-power mode.
  function automatic logic pm_allowed(logic [1:0] d);
    return !d[1];
  endfunction

endpackage

// File: rtl/clkpm_cfg.sv
module clkpm_cfg
  import clkpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cfg_t wr_cfg,
  input  logic evt,
  output cfg_t cfg_q,
  output logic swb_fire
);

  // A switchback only fires when armed, low power is on and no write wins.
  assign swb_fire = cfg_q.swb && cfg_q.pm && evt && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.div <= wr_cfg.div;
      cfg_q.swb <= wr_cfg.swb;
      cfg_q.alt <= wr_cfg.alt;
      cfg_q.pm  <= wr_cfg.pm && pm_allowed(wr_cfg.div);
    end else if (swb_fire) begin
      cfg_q.pm <= 1'b0;
    end
  end

endmodule

// File: rtl/clkpm_divider.sv
module clkpm_divider
  import clkpm_pkg::*;
#(
  parameter int unsigned PM_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       lf_tick,
  input  mode_e      req_mode,
  input  logic [1:0] req_div,
  output logic       fire,
  output mode_e      act_mode
);

  localparam int unsigned NORM_LOG2 = 3;
  localparam int unsigned CW = (PM_LOG2 > NORM_LOG2) ? PM_LOG2 : NORM_LOG2;

  logic [CW-1:0] cnt_q;
  logic [1:0]    act_div;
  logic          tick;
  logic          at_last;

  assign tick    = (act_mode == MODE_LF) ? lf_tick : src_tick;
  assign at_last = (act_mode == MODE_LF) ||
                   (cnt_q == CW'(last_count(act_mode, act_div, PM_LOG2)));
  assign fire    = tick && at_last;

  // The requested mode is only taken over at the end of a full period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      act_mode <= MODE_NORM;
      act_div  <= 2'd0;
    end else if (fire) begin
      cnt_q    <= '0;
      act_mode <= req_mode;
      act_div  <= req_div;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int unsigned PM_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_div,
  input  logic       wr_pm,
  input  logic       wr_swb,
  input  logic       wr_alt,
  input  logic       irq_evt,
  input  logic       ser_evt,
  input  logic       lf_tick,
  input  logic       alt_tick,
  output logic       sys_ce,
  output logic [1:0] cfg_div,
  output logic       cfg_pm,
  output logic       cfg_swb,
  output logic       cfg_alt,
  output logic       lp_active,
  output logic       lf_active,
  output logic       swb_taken
);

  cfg_t  wr_cfg;
  cfg_t  cfg;
  logic  evt;
  logic  swb_fire;
  logic  src_tick;
  logic  fire;
  mode_e act_mode;
  mode_e req_mode;

  assign wr_cfg   = '{div: wr_div, pm: wr_pm, swb: wr_swb, alt: wr_alt};
  assign evt      = irq_evt || ser_evt;
  assign req_mode = want_mode(cfg);
  assign src_tick = cfg.alt ? alt_tick : 1'b1;

  clkpm_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_cfg   (wr_cfg),
    .evt      (evt),
    .cfg_q    (cfg),
    .swb_fire (swb_fire)
  );

  clkpm_divider #(.PM_LOG2(PM_LOG2)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .lf_tick  (lf_tick),
    .req_mode (req_mode),
    .req_div  (cfg.div),
    .fire     (fire),
    .act_mode (act_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_ce    <= 1'b0;
      swb_taken <= 1'b0;
    end else begin
      sys_ce    <= fire;
      swb_taken <= swb_fire;
    end
  end

  assign cfg_div   = cfg.div;
  assign cfg_pm    = cfg.pm;
  assign cfg_swb   = cfg.swb;
  assign cfg_alt   = cfg.alt;
  assign lp_active = (act_mode != MODE_NORM);
  assign lf_active = (act_mode == MODE_LF);

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_div,
  input logic       wr_pm,
  input logic       lf_tick,
  input logic       alt_tick,
  input logic       sys_ce,
  input logic [1:0] cfg_div,
  input logic       cfg_pm,
  input logic       cfg_swb,
  input logic       cfg_alt,
  input logic       lp_active,
  input logic       lf_active,
  input logic       swb_taken,
  input logic       swb_fire,
  input logic       fire
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_rst_R1: assert (!sys_ce && !cfg_pm && !cfg_swb && !cfg_alt &&
                             cfg_div == 2'd0 && !lp_active && !swb_taken)
        else $error("reset state wrong");
    end
  end

  assert_pm_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pm |-> !cfg_div[1]);

  assert_swb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swb_fire |=> (!cfg_pm && swb_taken));

  assert_evt_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cfg_swb) |=> ($stable(cfg_pm) && !swb_taken));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_pm == ($past(wr_pm) && !$past(wr_div[1])) && !swb_taken));

  assert_lf_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_active && lf_tick) |=> sys_ce);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(lp_active) && $stable(lf_active)));

  assert_alt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_alt && !alt_tick && !lf_active) |=> !sys_ce);

endmodule

bind clkpm_ctrl clkpm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_div    (wr_div),
  .wr_pm     (wr_pm),
  .lf_tick   (lf_tick),
  .alt_tick  (alt_tick),
  .sys_ce    (sys_ce),
  .cfg_div   (cfg_div),
  .cfg_pm    (cfg_pm),
  .cfg_swb   (cfg_swb),
  .cfg_alt   (cfg_alt),
  .lp_active (lp_active),
  .lf_active (lf_active),
  .swb_taken (swb_taken),
  .swb_fire  (swb_fire),
  .fire      (fire)
);

// File: tb/clkpm_ctrl_bench.sv
`timescale 1ns/1ps
module clkpm_ctrl_bench;

  localparam int LF_PER   = 40;
  localparam int ALT_PER  = 3;
  localparam int PM_RATIO = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_div = 2'd0;
  logic       wr_pm = 1'b0;
  logic       wr_swb = 1'b0;
  logic       wr_alt = 1'b0;
  logic       irq_evt = 1'b0;
  logic       ser_evt = 1'b0;
  logic       lf_tick = 1'b0;
  logic       alt_tick = 1'b0;
  logic       sys_ce;
  logic [1:0] cfg_div;
  logic       cfg_pm, cfg_swb, cfg_alt, lp_active, lf_active, swb_taken;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkpm_ctrl u_clkpm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div), .wr_pm(wr_pm),
    .wr_swb(wr_swb), .wr_alt(wr_alt), .irq_evt(irq_evt), .ser_evt(ser_evt),
    .lf_tick(lf_tick), .alt_tick(alt_tick), .sys_ce(sys_ce), .cfg_div(cfg_div),
    .cfg_pm(cfg_pm), .cfg_swb(cfg_swb), .cfg_alt(cfg_alt),
    .lp_active(lp_active), .lf_active(lf_active), .swb_taken(swb_taken)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tick generators, both free-running.
  initial begin
    int lc = 0;
    int ac = 0;
    forever begin
      @(negedge clk);
      lc = (lc + 1) % LF_PER;
      ac = (ac + 1) % ALT_PER;
      lf_tick  = (lc == 0);
      alt_tick = (ac == 0);
    end
  end

  // Behavioural reference: mode 0 normal, 1 divide-by-256, 2 slow ticks.
  int m_div, m_pm, m_swb, m_alt, m_mode, m_adiv, m_cnt;
  bit e_ce, e_swb;

  always @(posedge clk) begin
    int rm, ratio;
    bit tk, fr, sf;
    if (!rst_n) begin
      m_div = 0; m_pm = 0; m_swb = 0; m_alt = 0;
      m_mode = 0; m_adiv = 0; m_cnt = 0; e_ce = 0; e_swb = 0;
    end else begin
      sf = (m_swb != 0) && (m_pm != 0) && (irq_evt || ser_evt) && !wr_en;
      if (m_pm != 0 && m_div == 0) rm = 1;
      else if (m_pm != 0 && m_div == 1) rm = 2;
      else rm = 0;
      if (m_mode == 2) begin
        tk = lf_tick;
        fr = lf_tick;
      end else begin
        tk = (m_alt != 0) ? alt_tick : 1'b1;
        ratio = (m_mode == 1) ? PM_RATIO : (1 << m_adiv);
        fr = tk && (m_cnt + 1 == ratio);
      end
      e_ce = fr;
      if (fr) begin
        m_cnt = 0; m_mode = rm; m_adiv = m_div;
      end else if (tk) begin
        m_cnt++;
      end
      e_swb = sf;
      if (wr_en) begin
        m_div = int'(wr_div); m_swb = int'(wr_swb); m_alt = int'(wr_alt);
        m_pm = (wr_pm && wr_div < 2) ? 1 : 0;
      end else if (sf) begin
        m_pm = 0;
      end
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tg;
      tg = (m_mode == 1) ? "R3 sys_ce/mode" : (m_mode == 2) ? "R4 sys_ce/mode" : "R2 sys_ce/mode";
      chk(sys_ce == e_ce && lp_active == (m_mode != 0) && lf_active == (m_mode == 2),
          tg, {lp_active, lf_active, sys_ce}, {m_mode != 0, m_mode == 2, e_ce});
      chk(cfg_pm == (m_pm != 0) && int'(cfg_div) == m_div && swb_taken == e_swb &&
          cfg_swb == (m_swb != 0) && cfg_alt == (m_alt != 0),
          "R6 cfg/swb", {cfg_div, cfg_pm, swb_taken}, {m_div[1:0], m_pm[0], e_swb});
    end
  end

  // All tasks start and end on a falling edge.
  task automatic wr(input int d, input bit pm, input bit swb, input bit alt);
    wr_en = 1; wr_div = d[1:0]; wr_pm = pm; wr_swb = swb; wr_alt = alt;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_ce(input int n, input int exp, input string tag);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (sys_ce) c++;
    end
    chk(c == exp, tag, c, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!sys_ce && !cfg_pm && cfg_div == 0 && !lp_active && !swb_taken && !cfg_alt,
        "R1 reset outputs", {cfg_div, cfg_pm, sys_ce}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sys_ce == 1, "R1 first enable", sys_ce, 1);
    count_ce(32, 32, "R1 default ratio 1");

    // R2: normal ratios
    wr(2, 0, 0, 0); idle(20); count_ce(64, 16, "R2 ratio 4");
    wr(3, 0, 0, 0); idle(20); count_ce(64, 8, "R2 ratio 8");
    wr(1, 0, 0, 0); idle(20); count_ce(64, 32, "R2 ratio 2");

    // R9: change from 8 to 1 mid-period
    wr(3, 0, 0, 0); idle(40);
    while (!sys_ce) @(negedge clk);
    begin
      int g = 1;
      wr(0, 0, 0, 0);
      while (!sys_ce) begin @(negedge clk); g++; end
      chk(g == 8, "R9 old period completes", g, 8);
      @(negedge clk);
      chk(sys_ce == 1, "R9 new ratio after terminal", sys_ce, 1);
    end

    // R3: divide by 256
    wr(0, 1, 0, 0); idle(600);
    chk(lp_active && !lf_active, "R3 status", {lp_active, lf_active}, 2);
    count_ce(512, 2, "R3 ratio 256");

    // R5: illegal low-power request
    wr(2, 1, 0, 0);
    chk(cfg_pm == 0 && cfg_div == 2, "R5 pm rejected", {cfg_div, cfg_pm}, 4);
    idle(600);

    // R4: slow-tick mode
    wr(1, 1, 0, 0); idle(300);
    chk(lp_active && lf_active, "R4 status", {lp_active, lf_active}, 3);
    count_ce(400, 10, "R4 follows slow ticks");

    // R7: event ignored with switchback off
    irq_evt = 1; @(negedge clk); irq_evt = 0;
    chk(cfg_pm == 1 && !swb_taken, "R7 irq ignored", {cfg_pm, swb_taken}, 2);
    ser_evt = 1; @(negedge clk); ser_evt = 0;
    chk(cfg_pm == 1 && !swb_taken, "R7 serial ignored", {cfg_pm, swb_taken}, 2);
    idle(5);
    chk(lf_active == 1, "R7 mode kept", lf_active, 1);

    // R6: switchback from slow-tick mode
    wr(1, 1, 1, 0); idle(10);
    ser_evt = 1; @(negedge clk); ser_evt = 0;
    chk(cfg_pm == 0 && swb_taken == 1, "R6 switchback", {cfg_pm, swb_taken}, 1);
    idle(100);
    chk(lp_active == 0, "R6 back to normal", lp_active, 0);
    count_ce(64, 32, "R6 normal ratio 2");

    // R8: write beats a same-cycle event
    wr(1, 1, 1, 0); idle(5);
    wr_en = 1; wr_div = 2'd1; wr_pm = 1; wr_swb = 1; wr_alt = 0; irq_evt = 1;
    @(negedge clk);
    wr_en = 0; irq_evt = 0;
    chk(cfg_pm == 1 && swb_taken == 0, "R8 write wins", {cfg_pm, swb_taken}, 2);
    idle(3);
    irq_evt = 1; @(negedge clk); irq_evt = 0;
    chk(cfg_pm == 0 && swb_taken == 1, "R6 irq switchback", {cfg_pm, swb_taken}, 1);
    idle(100);

    // R10: alternate source
    wr(0, 0, 0, 1); idle(60);
    count_ce(60, 20, "R10 alt ticks counted");
    wr(1, 0, 0, 1); idle(20);
    count_ce(120, 20, "R10 alt ratio 2");
    wr(0, 1, 0, 1); idle(1600);
    count_ce(1536, 2, "R10 alt divide 256");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule